// File: doc/BRIEF.md
# Gated Serial Clock Generator

This block makes the shift clock for a small serial shift engine. It picks one of five clock sources: two internal clocks, the external clock pin, a clock bit that software toggles, and a timer compare output. It counts rising edges of the chosen source and divides them by a power of two. From that count it builds a pin clock with a programmable idle level. It also issues single-cycle strobes that tell the shift engine when to change output data and when to sample input data. All source inputs are treated as slow levels and are resynchronised to the block clock `clk`.

The clock stops itself when the bit-counter completion flag or the START-detected flag is pending. It leaves the pin at its idle level, so releasing a flag never produces a shortened pulse. Because one source is a software-written bit, software can step the clock one edge at a time. In slave mode the pin is an input. Its edges drive the strobes directly, and the source selection and the divider are not used.

A four-state machine controls the gate:
- `ST_HOLD`: soft reset is active.
- `ST_PARK`: the pin is idle and the gate is closed.
- `ST_LEAD_WAIT`: the pin is idle, the gate is open, and the machine waits for a leading edge.
- `ST_TRAIL_WAIT`: the pin is active and the machine waits for the trailing edge.

Transitions:
- HOLD to PARK when soft reset falls.
- PARK to LEAD_WAIT once both flags are clear.
- LEAD_WAIT to PARK when a flag rises.
- LEAD_WAIT to TRAIL_WAIT on a leading event (leading edge).
- TRAIL_WAIT to LEAD_WAIT or PARK on a trailing event (trailing edge), depending on the flags.
- Any state to HOLD while soft reset is high.

Top module: `sclk_gen`

## Requirements
- R1: While `soft_rst` is high the pin clock sits at its idle level, no strobe fires, and the divider count is cleared. Asserting it during the active half returns the pin to idle within two clocks.
- R2: `src_sel` picks the source. Code 0 selects `int_clk_a`, 1 selects `int_clk_b`, 2 selects `pin_clk_in`, 3 selects `soft_clk` and 4 selects `timer_out`. Codes 5 to 7 select nothing. Only rising edges of the selected source advance the clock.
- R3: With `div_sel` = k, the pin clock makes one edge per 2^k rising edges of the selected source. Counting restarts from zero whenever the gate reopens.
- R4: The idle level of `pin_clk_out` equals `cpol`, and the active level is its inverse.
- R5: With `cpha` = 0, `shift_stb` fires at the leading edge (idle to active) and `sample_stb` fires at the trailing edge.
- R6: With `cpha` = 1, `sample_stb` fires at the leading edge and `shift_stb` fires at the trailing edge.
- R7: While `done_flag` is high no leading edge is produced.
- R8: While `start_flag` is high no leading edge is produced, and `pin_clk_oe` is unaffected.
- R9: A flag raised during the active half lets the trailing edge complete. The pin then stays at idle until the flag clears and a further full edge count has passed.
- R10: `pin_clk_oe` is high exactly when `master` = 1, `done_flag` = 0 and `soft_rst` = 0.
- R11: With `master` = 0, each resynchronised `pin_clk_in` change to the active level is a leading event, and each change back to idle is a trailing event. In this mode `src_sel` and `div_sel` have no effect.
- R12: The two strobes never fire together. Each strobe cycle is followed in the next cycle by a change of `pin_clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset; holds the clock idle |
| int_clk_a | input | 1 | Internal clock source, code 0 |
| int_clk_b | input | 1 | Internal clock source, code 1 |
| pin_clk_in | input | 1 | Clock pin input, code 2 and slave clock |
| soft_clk | input | 1 | Software clock bit, code 3 |
| timer_out | input | 1 | Timer compare output, code 4 |
| src_sel | input | 3 | Source select code |
| div_sel | input | 3 | Divide ratio exponent |
| cpol | input | 1 | Idle level of the pin clock |
| cpha | input | 1 | Phase select for the strobes |
| master | input | 1 | 1 = drive the pin, 0 = take clock from the pin |
| done_flag | input | 1 | Bit-counter completion flag pending |
| start_flag | input | 1 | START-detected flag pending |
| shift_stb | output | 1 | Change-output-data strobe |
| sample_stb | output | 1 | Sample-input-data strobe |
| pin_clk_out | output | 1 | Pin clock value |
| pin_clk_oe | output | 1 | Pin clock output enable |

## Verification
The bench steps the clock with single software pulses, so it can count exactly how many source edges precede each pin edge. This tells divide ratios 1, 4 and 128 apart, and shows whether counting restarts after a reset. Each source code is pulsed alongside the software bit, which separates the correct source from a wrong one and from the dead codes. The flags are raised both at the idle level and during the active half, which separates blocking only the leading edge from cutting the pulse short. Slave mode is driven from the pin, with pulses on the ignored software source mixed in.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;
    localparam int NUM_SRC = 5;
    localparam logic [2:0] SRC_INT_A = 3'd0;
    localparam logic [2:0] SRC_INT_B = 3'd1;
    localparam logic [2:0] SRC_PIN   = 3'd2;
    localparam logic [2:0] SRC_SOFT  = 3'd3;
    localparam logic [2:0] SRC_TIMER = 3'd4;

    typedef enum logic [1:0] {
        ST_HOLD       = 2'd0,
        ST_PARK       = 2'd1,
        ST_LEAD_WAIT  = 2'd2,
        ST_TRAIL_WAIT = 2'd3
    } gate_state_e;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sclk_src_mux.sv
module sclk_src_mux
    import sclk_gen_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [SEL_W-1:0]   sel,
    output logic               src_rise
);
    logic cur_lvl;
    logic prev_lvl;

    always_comb begin
        case (3'(sel))
            SRC_INT_A: cur_lvl = src_lvl[0];
            SRC_INT_B: cur_lvl = src_lvl[1];
            SRC_PIN:   cur_lvl = src_lvl[2];
            SRC_SOFT:  cur_lvl = src_lvl[3];
            SRC_TIMER: cur_lvl = src_lvl[4];
            default:   cur_lvl = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= cur_lvl;
    end

    assign src_rise = cur_lvl & ~prev_lvl;
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_rise,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   last;

    assign span = (CNT_W+1)'(1) << ratio;
    assign last = span - (CNT_W+1)'(1);
    assign tick = src_rise && !clr && (cnt == last[CNT_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (src_rise) cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/sclk_gate_fsm.sv
module sclk_gate_fsm
    import sclk_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic flag_pend,
    input  logic lead_ev,
    input  logic trail_ev,
    input  logic cpha,
    output logic lvl_active,
    output logic div_clr,
    output logic shift_stb,
    output logic sample_stb
);
    gate_state_e state_q, state_d;
    logic lead_go, trail_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:       state_d = ST_PARK;
                ST_PARK:       if (!flag_pend) state_d = ST_LEAD_WAIT;
                ST_LEAD_WAIT:  if (flag_pend)  state_d = ST_PARK;
                               else if (lead_ev) state_d = ST_TRAIL_WAIT;
                ST_TRAIL_WAIT: if (trail_ev)
                                   state_d = flag_pend ? ST_PARK : ST_LEAD_WAIT;
            endcase
        end
    end

    always_comb begin
        lead_go    = (state_q == ST_LEAD_WAIT) && !soft_rst && !flag_pend && lead_ev;
        trail_go   = (state_q == ST_TRAIL_WAIT) && !soft_rst && trail_ev;
        lvl_active = (state_q == ST_TRAIL_WAIT);
        div_clr    = (state_q == ST_HOLD) || (state_q == ST_PARK) || soft_rst;
        shift_stb  = cpha ? trail_go : lead_go;
        sample_stb = cpha ? lead_go  : trail_go;
    end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_gen_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int DIV_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             int_clk_a,
    input  logic             int_clk_b,
    input  logic             pin_clk_in,
    input  logic             soft_clk,
    input  logic             timer_out,
    input  logic [SEL_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             master,
    input  logic             done_flag,
    input  logic             start_flag,
    output logic             shift_stb,
    output logic             sample_stb,
    output logic             pin_clk_out,
    output logic             pin_clk_oe
);
    logic [NUM_SRC-1:0] src_raw, src_lvl;
    logic src_rise, div_tick, div_clr, lvl_active;
    logic pin_act, pin_act_q;
    logic lead_ev, trail_ev, flag_pend;

    assign src_raw   = {timer_out, soft_clk, pin_clk_in, int_clk_b, int_clk_a};
    assign flag_pend = done_flag | start_flag;

    sclk_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_raw), .q(src_lvl)
    );

    sclk_src_mux #(.SEL_W(SEL_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .sel(src_sel), .src_rise(src_rise)
    );

    sclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(div_clr), .src_rise(src_rise),
        .ratio(div_sel), .tick(div_tick)
    );

    assign pin_act = src_lvl[2] ^ cpol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_act_q <= 1'b0;
        else        pin_act_q <= pin_act;
    end

    assign lead_ev  = master ? div_tick : (pin_act & ~pin_act_q);
    assign trail_ev = master ? div_tick : (~pin_act & pin_act_q);

    sclk_gate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flag_pend(flag_pend),
        .lead_ev(lead_ev), .trail_ev(trail_ev), .cpha(cpha),
        .lvl_active(lvl_active), .div_clr(div_clr),
        .shift_stb(shift_stb), .sample_stb(sample_stb)
    );

    assign pin_clk_out = lvl_active ^ cpol;
    assign pin_clk_oe  = master & ~done_flag & ~soft_rst;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
    parameter int SEL_W = 3,
    parameter int DIV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             cpol,
    input logic             master,
    input logic             done_flag,
    input logic             start_flag,
    input logic             shift_stb,
    input logic             sample_stb,
    input logic             pin_clk_out,
    input logic             pin_clk_oe
);
    logic act;
    assign act = pin_clk_out ^ cpol;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && $past(soft_rst)) |-> (pin_clk_out == cpol)) else $error("hold idle"); // R1

    AST_NO_LEAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !$past(act)) |-> !$past(done_flag || start_flag)) else $error("lead under flag"); // R7

    AST_OE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_clk_oe |-> (master && !done_flag)) else $error("oe rule"); // R10

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_stb && sample_stb)) else $error("strobe overlap"); // R12

    AST_STB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb || sample_stb) |=> (act != $past(act))) else $error("strobe without edge"); // R12
endmodule

bind sclk_gen sclk_gen_chk #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sclk_gen_tb.sv
`timescale 1ns/1ps
module sclk_gen_tb;
    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b1;
    logic int_clk_a = 0, int_clk_b = 0, pin_clk_in = 0, soft_clk = 0, timer_out = 0;
    logic [2:0] src_sel = 3'd3, div_sel = 3'd0;
    logic cpol = 0, cpha = 0, master = 1, done_flag = 0, start_flag = 0;
    logic shift_stb, sample_stb, pin_clk_out, pin_clk_oe;

    int checks = 0, errors = 0, sh_cnt = 0, sa_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sclk_gen u_dut (.*);

    always @(posedge clk) begin
        if (shift_stb)  sh_cnt <= sh_cnt + 1;
        if (sample_stb) sa_cnt <= sa_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int code);
        @(negedge clk);
        case (code)
            0: int_clk_a = 1; 1: int_clk_b = 1; 2: pin_clk_in = 1;
            3: soft_clk = 1;  default: timer_out = 1;
        endcase
        idle(4);
        {int_clk_a, int_clk_b, pin_clk_in, soft_clk, timer_out} = '0;
        idle(4);
    endtask

    task automatic pulses(input int code, input int n);
        for (int i = 0; i < n; i++) pulse(code);
    endtask

    task automatic sreset();
        @(negedge clk); soft_rst = 1; idle(3); soft_rst = 0; idle(3);
    endtask

    task automatic t_reset();
        chk("R1 pin idle in reset", pin_clk_out, 0);
        chk("R10 oe low in reset", pin_clk_oe, 0);
        pulses(3, 2);
        chk("R1 no strobes in reset", sh_cnt + sa_cnt, 0);
        chk("R1 pin stays idle", pin_clk_out, 0);
        cpol = 1; idle(2);
        chk("R4 idle follows cpol in reset", pin_clk_out, 1);
        cpol = 0; soft_rst = 0; idle(3);
        chk("R10 oe high as master", pin_clk_oe, 1);
    endtask

    task automatic t_phase0();
        int s0 = sh_cnt, a0 = sa_cnt;
        pulse(3);
        chk("R5 leading edge", pin_clk_out, 1);
        chk("R5 shift at lead", sh_cnt - s0, 1);
        chk("R5 no sample at lead", sa_cnt - a0, 0);
        pulse(3);
        chk("R5 trailing edge", pin_clk_out, 0);
        chk("R5 sample at trail", sa_cnt - a0, 1);
    endtask

    task automatic t_phase1();
        int s0, a0;
        cpha = 1; s0 = sh_cnt; a0 = sa_cnt;
        pulse(3);
        chk("R6 sample at lead", sa_cnt - a0, 1);
        chk("R6 no shift at lead", sh_cnt - s0, 0);
        pulse(3);
        chk("R6 shift at trail", sh_cnt - s0, 1);
        cpha = 0;
    endtask

    task automatic t_polarity();
        cpol = 1; sreset();
        chk("R4 idle high", pin_clk_out, 1);
        pulse(3);
        chk("R4 active low", pin_clk_out, 0);
        pulse(3);
        chk("R4 back idle", pin_clk_out, 1);
        cpol = 0; sreset();
    endtask

    task automatic t_divider();
        div_sel = 3'd2; sreset();
        pulses(3, 3);
        chk("R3 div4 no edge after 3", pin_clk_out, 0);
        pulse(3);
        chk("R3 div4 edge after 4", pin_clk_out, 1);
        pulses(3, 4);
        chk("R3 div4 second edge", pin_clk_out, 0);
        div_sel = 3'd7; sreset();
        pulses(3, 127);
        chk("R3 div128 no edge after 127", pin_clk_out, 0);
        pulse(3);
        chk("R3 div128 edge after 128", pin_clk_out, 1);
        div_sel = 3'd0; sreset();
    endtask

    task automatic t_sources();
        for (int c = 0; c < 5; c++) begin
            if (c == 3) continue;
            src_sel = 3'(c); sreset();
            pulse(3);
            chk("R2 other source ignored", pin_clk_out, 0);
            pulse(c);
            chk("R2 selected source steps", pin_clk_out, 1);
        end
        src_sel = 3'd6; sreset();
        for (int c = 0; c < 5; c++) pulse(c);
        chk("R2 dead code no edge", pin_clk_out, 0);
        src_sel = 3'd3; sreset();
    endtask

    task automatic t_flags();
        int n0;
        done_flag = 1; idle(2);
        chk("R10 oe low on done", pin_clk_oe, 0);
        n0 = sh_cnt + sa_cnt;
        pulses(3, 2);
        chk("R7 done blocks clock", pin_clk_out, 0);
        chk("R7 done blocks strobes", sh_cnt + sa_cnt - n0, 0);
        done_flag = 0; idle(2);
        pulse(3);
        chk("R7 resume after done", pin_clk_out, 1);
        pulse(3);
        start_flag = 1; idle(2);
        chk("R8 oe kept on start", pin_clk_oe, 1);
        pulses(3, 2);
        chk("R8 start blocks clock", pin_clk_out, 0);
        start_flag = 0; idle(2);
        pulse(3);
        n0 = sa_cnt;
        start_flag = 1; idle(2);
        chk("R9 active half kept", pin_clk_out, 1);
        pulse(3);
        chk("R9 trailing completes", pin_clk_out, 0);
        chk("R9 trailing strobe", sa_cnt - n0, 1);
        pulse(3);
        chk("R9 parked idle", pin_clk_out, 0);
        start_flag = 0; idle(2);
        pulse(3);
        chk("R9 restart full edge", pin_clk_out, 1);
        @(negedge clk); soft_rst = 1; idle(2);
        chk("R1 reset forces idle", pin_clk_out, 0);
        soft_rst = 0; idle(3);
    endtask

    task automatic t_slave();
        int s0, a0;
        master = 0; div_sel = 3'd5; sreset();
        chk("R10 oe low as slave", pin_clk_oe, 0);
        s0 = sh_cnt; a0 = sa_cnt;
        pulse(3);
        chk("R11 select ignored in slave", sh_cnt - s0, 0);
        @(negedge clk); pin_clk_in = 1; idle(5);
        chk("R11 pin lead gives shift", sh_cnt - s0, 1);
        chk("R11 pin lead, pin tracks", pin_clk_out, 1);
        pin_clk_in = 0; idle(5);
        chk("R11 pin trail gives sample", sa_cnt - a0, 1);
        start_flag = 1; idle(2);
        pin_clk_in = 1; idle(5); pin_clk_in = 0; idle(5);
        chk("R8 start blocks slave", sh_cnt - s0, 1);
        start_flag = 0; master = 1; div_sel = 3'd0; sreset();
    endtask

    initial begin
        idle(3); rst_n = 1; idle(3);
        t_reset();
        t_phase0();
        t_phase1();
        t_polarity();
        t_divider();
        t_sources();
        t_flags();
        t_slave();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule